// File: doc/BRIEF.md
# Timer Trigger-Input Clock Selector

This block sits in front of a general-purpose up-counter and decides what advances it. In the default mode the counter steps on every kernel clock. In the external-edge mode it steps once for each active edge of a chosen trigger source. There are four pin-level sources: channel 1, channel 2, the external trigger pin, and an edge-combined form of channel 1. There are also four internal trigger lines that arrive already synchronous to the kernel clock.

Each pin passes through three stages: a two-flop synchroniser, a programmable run-length glitch filter, and an edge detector. Per-source polarity bits then choose the active edge. A 5-bit selector picks the trigger source, and a 3-bit mode field switches the counter between the kernel clock and the trigger. Every active trigger edge also sets a sticky flag, which a one-cycle clear pulse resets. All configuration arrives as plain field inputs.

Top module: `tsel_top`

## Requirements
- R1: While rst_n is low at a clock edge, count and trig_flag both become 0.
- R2: When slave_mode is not 3'b111 and count_en is 1, count rises by one on every clock edge and wraps modulo 2^CNT_W.
- R3: While count_en is 0, count does not change, whatever trigger edges arrive.
- R4: With slave_mode 3'b111, trig_sel 5'b00110, ch2_map 2'b01, ch2_inv 0, ch2_both 0 and ch2_flt 0, a rising edge on ch2_pin raises count by exactly one at the third rising clock edge after the pin change, and a falling edge has no effect.
- R5: For channel 2, ch2_both=1 makes both edges active. With ch2_both=0, ch2_inv=1 makes only the falling edge active. The same two bits act the same way on channel 1 when trig_sel is 5'b00101.
- R6: A nonzero filter length N lets the filtered level change only after N consecutive kernel samples that disagree with it. A pin pulse shorter than N cycles is ignored, and the increment moves to the (3+N)th clock edge after the pin change.
- R7: trig_sel 5'b00100 counts both edges of the filtered channel 1 signal and ignores ch1_inv and ch1_both.
- R8: trig_sel 5'b00111 selects the external pin. ext_inv=0 makes the rising edge active and ext_inv=1 the falling edge.
- R9: trig_sel 5'b000xx selects internal line itr_in[xx]. A rising edge there counts once, at the first clock edge that samples it high. The other lines have no effect.
- R10: trig_sel codes 5'b01000 to 5'b11111 select no source: count does not move in external-edge mode and trig_flag is not set.
- R11: With trig_sel 5'b00110 and ch2_map other than 2'b01, channel 2 edges are not counted and do not set trig_flag.
- R12: Each active edge of the selected trigger sets trig_flag. flag_clr high for a cycle clears it. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch1_pin | input | 1 | Channel 1 pin, asynchronous |
| ch2_pin | input | 1 | Channel 2 pin, asynchronous |
| ext_pin | input | 1 | External trigger pin, asynchronous |
| itr_in | input | 4 | Internal trigger lines, kernel-synchronous |
| trig_sel | input | 5 | Trigger source code |
| slave_mode | input | 3 | 3'b111 = external-edge counting, else kernel clock |
| ch2_map | input | 2 | Channel 2 input mapping; 2'b01 enables it as trigger |
| ch1_flt | input | 4 | Channel 1 filter run length (0 = off) |
| ch2_flt | input | 4 | Channel 2 filter run length (0 = off) |
| ext_flt | input | 4 | External pin filter run length (0 = off) |
| ch1_inv | input | 1 | Channel 1 falling-edge select |
| ch1_both | input | 1 | Channel 1 both-edges select |
| ch2_inv | input | 1 | Channel 2 falling-edge select |
| ch2_both | input | 1 | Channel 2 both-edges select |
| ext_inv | input | 1 | External pin falling-edge select |
| count_en | input | 1 | Counter enable |
| flag_clr | input | 1 | One-cycle trigger flag clear |
| count | output | CNT_W | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The bench first runs the counter from the kernel clock, then drives single rising and falling pin edges in every polarity setting. Those edges show whether each edge kind is counted and whether the three-cycle latency is right. Filtered runs send a pulse one cycle too short, then a held level. This separates rejection from a shifted latency. Source-selection passes toggle every unselected pin and line, and also try reserved codes and an unmapped channel 2. Any leak between the multiplexer inputs shows up as a count.

// File: rtl/tsel_pkg.sv
// Shared codes for the trigger-input clock selector.
// Assumes a 5-bit source code and a 3-bit mode field.
package tsel_pkg;
    localparam int          N_ITR      = 4;
    localparam int          N_SRC      = 3;
    localparam int          SRC_CH1    = 0;
    localparam int          SRC_CH2    = 1;
    localparam int          SRC_EXT    = 2;
    localparam logic [4:0]  TS_CH1_ANY = 5'b00100;
    localparam logic [4:0]  TS_CH1_POL = 5'b00101;
    localparam logic [4:0]  TS_CH2_POL = 5'b00110;
    localparam logic [4:0]  TS_EXT_POL = 5'b00111;
    localparam logic [2:0]  MODE_EXT1  = 3'b111;
    localparam logic [1:0]  MAP_CH2_IN = 2'b01;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/tsel_input_cond.sv
// Pin conditioner: synchroniser, run-length glitch filter, edge detector.
// Assumes pin_i is asynchronous. A filter length of 0 bypasses the filter.
module tsel_input_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FLT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [FLT_W-1:0] flt_len_i,
    output tsel_pkg::edge_t  edge_o
);
    localparam int RUN_W = FLT_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic [FLT_W-1:0]       run_q;
    logic                   lvl_q;
    logic                   filt_lvl;
    logic                   prev_q;
    logic [RUN_W-1:0]       run_next;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
    assign sync_lvl = sync_q[SYNC_STAGES-1];

    assign run_next = {1'b0, run_q} + RUN_W'(1);

    // Count consecutive disagreeing samples; adopt the new level after N of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else if (sync_lvl == lvl_q) begin
            run_q <= '0;
        end else if (run_next >= {1'b0, flt_len_i}) begin
            run_q <= '0;
            lvl_q <= sync_lvl;
        end else begin
            run_q <= run_next[FLT_W-1:0];
        end
    end

    assign filt_lvl = (flt_len_i == '0) ? sync_lvl : lvl_q;

    // Remember the last filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= filt_lvl;
    end

    assign edge_o.rise = filt_lvl & ~prev_q;
    assign edge_o.fall = ~filt_lvl & prev_q;

    AST_FILTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_len_i != '0 && $past(flt_len_i) != '0 && lvl_q != $past(lvl_q))
            |-> $past(sync_lvl) == lvl_q)
        else $error("filtered level moved against the sampled input"); // R6
endmodule

// File: rtl/tsel_trig_mux.sv
// Trigger source multiplexer with per-source active-edge selection.
// Assumes itr_i is synchronous to clk; pin edges come from the conditioners.
module tsel_trig_mux (
    input  logic                         clk,
    input  logic                         rst_n,
    input  tsel_pkg::edge_t              ch1_edge_i,
    input  tsel_pkg::edge_t              ch2_edge_i,
    input  tsel_pkg::edge_t              ext_edge_i,
    input  logic [tsel_pkg::N_ITR-1:0]   itr_i,
    input  logic [4:0]                   trig_sel_i,
    input  logic [1:0]                   ch2_map_i,
    input  logic                         ch1_inv_i,
    input  logic                         ch1_both_i,
    input  logic                         ch2_inv_i,
    input  logic                         ch2_both_i,
    input  logic                         ext_inv_i,
    output logic                         trgi_pulse_o
);
    import tsel_pkg::*;

    localparam int ITR_SEL_W = $clog2(N_ITR);

    logic [N_ITR-1:0] itr_prev_q;
    logic [N_ITR-1:0] itr_rise;

    function automatic logic pick_edge(input edge_t e, input logic inv, input logic both);
        if (both)     return e.rise | e.fall;
        else if (inv) return e.fall;
        else          return e.rise;
    endfunction

    // Hold last internal trigger levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) itr_prev_q <= '0;
        else        itr_prev_q <= itr_i;
    end
    assign itr_rise = itr_i & ~itr_prev_q;

    // Route the selected source's active edge to the trigger pulse.
    always_comb begin
        trgi_pulse_o = 1'b0;
        if (trig_sel_i[4:ITR_SEL_W] == '0) begin
            trgi_pulse_o = itr_rise[trig_sel_i[ITR_SEL_W-1:0]];
        end else begin
            case (trig_sel_i)
                TS_CH1_ANY: trgi_pulse_o = ch1_edge_i.rise | ch1_edge_i.fall;
                TS_CH1_POL: trgi_pulse_o = pick_edge(ch1_edge_i, ch1_inv_i, ch1_both_i);
                TS_CH2_POL: trgi_pulse_o = (ch2_map_i == MAP_CH2_IN)
                                           & pick_edge(ch2_edge_i, ch2_inv_i, ch2_both_i);
                TS_EXT_POL: trgi_pulse_o = ext_inv_i ? ext_edge_i.fall : ext_edge_i.rise;
                default:    trgi_pulse_o = 1'b0;
            endcase
        end
    end

    AST_ITR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel_i[4:ITR_SEL_W] == '0 && $stable(trig_sel_i) && $stable(itr_i)) |-> !trgi_pulse_o)
        else $error("internal trigger pulsed without a new edge"); // R9
endmodule

// File: rtl/tsel_counter.sv
// Up-counter with a kernel-clock or trigger-edge step, plus a sticky trigger flag.
// Assumes trgi_pulse_i is a single-cycle pulse per active edge.
module tsel_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en_i,
    input  logic             ext_mode_i,
    input  logic             trgi_pulse_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             trig_flag_o
);
    logic step;

    assign step = count_en_i & (~ext_mode_i | trgi_pulse_i);

    // Advance the counter by one on each granted step.
    always_ff @(posedge clk) begin
        if (!rst_n)    count_o <= '0;
        else if (step) count_o <= count_o + CNT_W'(1);
    end

    // Set the flag on each trigger edge; clear on request, set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)            trig_flag_o <= 1'b0;
        else if (trgi_pulse_i) trig_flag_o <= 1'b1;
        else if (flag_clr_i)   trig_flag_o <= 1'b0;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en_i |=> count_o == $past(count_o))
        else $error("counter moved while disabled"); // R3
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !ext_mode_i) |=> count_o == $past(count_o) + CNT_W'(1))
        else $error("counter missed a kernel step"); // R2
    AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && ext_mode_i) |=> count_o == $past(count_o) + CNT_W'($past(trgi_pulse_i)))
        else $error("counter step does not match trigger edge"); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trgi_pulse_i |=> trig_flag_o)
        else $error("trigger flag not set by edge"); // R12
endmodule

// File: rtl/tsel_top.sv
// Trigger-input clock selector: conditions three pins, selects a trigger,
// and drives the counter. Assumes all configuration fields are static
// or change only between trigger edges.
module tsel_top #(
    parameter int CNT_W       = 16,
    parameter int FLT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch1_pin,
    input  logic             ch2_pin,
    input  logic             ext_pin,
    input  logic [3:0]       itr_in,
    input  logic [4:0]       trig_sel,
    input  logic [2:0]       slave_mode,
    input  logic [1:0]       ch2_map,
    input  logic [FLT_W-1:0] ch1_flt,
    input  logic [FLT_W-1:0] ch2_flt,
    input  logic [FLT_W-1:0] ext_flt,
    input  logic             ch1_inv,
    input  logic             ch1_both,
    input  logic             ch2_inv,
    input  logic             ch2_both,
    input  logic             ext_inv,
    input  logic             count_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             trig_flag
);
    import tsel_pkg::*;

    logic [N_SRC-1:0] pin_vec;
    logic [FLT_W-1:0] flt_vec [N_SRC];
    edge_t            edge_vec [N_SRC];
    logic             trgi_pulse;
    logic             ext_mode;

    assign pin_vec[SRC_CH1] = ch1_pin;
    assign pin_vec[SRC_CH2] = ch2_pin;
    assign pin_vec[SRC_EXT] = ext_pin;
    assign flt_vec[SRC_CH1] = ch1_flt;
    assign flt_vec[SRC_CH2] = ch2_flt;
    assign flt_vec[SRC_EXT] = ext_flt;

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_cond
        tsel_input_cond #(
            .SYNC_STAGES (SYNC_STAGES),
            .FLT_W       (FLT_W)
        ) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_vec[gi]),
            .flt_len_i (flt_vec[gi]),
            .edge_o    (edge_vec[gi])
        );
    end

    tsel_trig_mux u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch1_edge_i   (edge_vec[SRC_CH1]),
        .ch2_edge_i   (edge_vec[SRC_CH2]),
        .ext_edge_i   (edge_vec[SRC_EXT]),
        .itr_i        (itr_in),
        .trig_sel_i   (trig_sel),
        .ch2_map_i    (ch2_map),
        .ch1_inv_i    (ch1_inv),
        .ch1_both_i   (ch1_both),
        .ch2_inv_i    (ch2_inv),
        .ch2_both_i   (ch2_both),
        .ext_inv_i    (ext_inv),
        .trgi_pulse_o (trgi_pulse)
    );

    assign ext_mode = (slave_mode == MODE_EXT1);

    tsel_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_en_i   (count_en),
        .ext_mode_i   (ext_mode),
        .trgi_pulse_i (trgi_pulse),
        .flag_clr_i   (flag_clr),
        .count_o      (count),
        .trig_flag_o  (trig_flag)
    );

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel[4:3] != 2'b00 && !trig_flag) |=> !trig_flag)
        else $error("reserved trigger code raised the flag"); // R10
    AST_CH2_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == TS_CH2_POL && ch2_map != MAP_CH2_IN && !trig_flag) |=> !trig_flag)
        else $error("unmapped channel 2 raised the flag"); // R11
endmodule

// File: tb/tsel_top_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected values, the monitor compares them.
module tsel_top_bench;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch1_pin = 0, ch2_pin = 0, ext_pin = 0;
    logic [3:0] itr_in = '0;
    logic [4:0] trig_sel = '0;
    logic [2:0] slave_mode = '0;
    logic [1:0] ch2_map = '0;
    logic [3:0] ch1_flt = '0, ch2_flt = '0, ext_flt = '0;
    logic ch1_inv = 0, ch1_both = 0, ch2_inv = 0, ch2_both = 0, ext_inv = 0;
    logic count_en = 0, flag_clr = 0;
    logic [CNT_W-1:0] count;
    logic trig_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 0;

    typedef struct {
        string tag;
        int    cnt;
        bit    use_flg;
        bit    flg;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tsel_top #(.CNT_W(CNT_W)) u_tsel_top (
        .clk(clk), .rst_n(rst_n), .ch1_pin(ch1_pin), .ch2_pin(ch2_pin), .ext_pin(ext_pin),
        .itr_in(itr_in), .trig_sel(trig_sel), .slave_mode(slave_mode), .ch2_map(ch2_map),
        .ch1_flt(ch1_flt), .ch2_flt(ch2_flt), .ext_flt(ext_flt),
        .ch1_inv(ch1_inv), .ch1_both(ch1_both), .ch2_inv(ch2_inv), .ch2_both(ch2_both),
        .ext_inv(ext_inv), .count_en(count_en), .flag_clr(flag_clr),
        .count(count), .trig_flag(trig_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_cnt(input string tag);
        item_t it;
        it.tag = tag; it.cnt = exp_cnt; it.use_flg = 0; it.flg = 0;
        sb_q.push_back(it);
    endtask

    task automatic expect_both(input string tag, input bit flg);
        item_t it;
        it.tag = tag; it.cnt = exp_cnt; it.use_flg = 1; it.flg = flg;
        sb_q.push_back(it);
    endtask

    task automatic clear_flag();
        flag_clr = 1; tick(1); flag_clr = 0;
    endtask

    // Monitor: compare queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (count != CNT_W'(it.cnt)) begin
                    n_bad++;
                    $display("FAIL %s: count actual %0d expected %0d", it.tag, count, CNT_W'(it.cnt));
                end else if (it.use_flg && trig_flag != it.flg) begin
                    n_bad++;
                    $display("FAIL %s: trig_flag actual %0b expected %0b", it.tag, trig_flag, it.flg);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(4);
        rst_n = 1;
        expect_both("R1 reset state", 0);
        tick(5);
        expect_cnt("R3 disabled free run");

        count_en = 1; tick(5); exp_cnt += 5;
        expect_both("R2 kernel clock count", 0);
        count_en = 0; tick(3);
        expect_cnt("R3 hold after disable");

        slave_mode = 3'b111; trig_sel = 5'b00110; ch2_map = 2'b01; count_en = 1;
        tick(3);
        expect_both("R4 idle ext mode", 0);
        ch2_pin = 1; tick(2);
        expect_cnt("R4 before latency");
        tick(1); exp_cnt += 1;
        expect_both("R4 third edge", 1);
        ch2_pin = 0; tick(5);
        expect_cnt("R4 falling ignored");
        clear_flag();
        expect_both("R12 clear", 0);

        ch2_inv = 1; ch2_pin = 1; tick(5);
        expect_cnt("R5 rise ignored when inverted");
        ch2_pin = 0; tick(5); exp_cnt += 1;
        expect_cnt("R5 falling counted");
        ch2_both = 1; ch2_pin = 1; tick(5); exp_cnt += 1;
        expect_cnt("R5 both rise");
        ch2_pin = 0; tick(5); exp_cnt += 1;
        expect_cnt("R5 both fall");
        ch2_inv = 0; ch2_both = 0;

        ch2_flt = 4'd4; ch2_pin = 1; tick(3); ch2_pin = 0; tick(8);
        expect_cnt("R6 short pulse rejected");
        ch2_pin = 1; tick(6);
        expect_cnt("R6 before filtered latency");
        tick(1); exp_cnt += 1;
        expect_cnt("R6 count at 3+N");
        ch2_pin = 0; tick(10); ch2_flt = '0;
        expect_cnt("R6 filtered fall ignored");

        count_en = 0; ch2_pin = 1; tick(5);
        expect_cnt("R3 ext edge while disabled");
        ch2_pin = 0; tick(5); count_en = 1;

        clear_flag();
        ch2_map = 2'b10; ch2_pin = 1; tick(5); ch2_pin = 0; tick(5);
        expect_both("R11 unmapped channel 2", 0);
        ch2_map = 2'b01;

        trig_sel = 5'b00100; ch1_inv = 1;
        ch1_pin = 1; tick(5); exp_cnt += 1;
        expect_cnt("R7 combined rise");
        ch1_pin = 0; tick(5); exp_cnt += 1;
        expect_cnt("R7 combined fall");
        trig_sel = 5'b00101;
        ch1_pin = 1; tick(5);
        expect_cnt("R5 channel 1 inverted rise ignored");
        ch1_pin = 0; tick(5); exp_cnt += 1;
        expect_cnt("R5 channel 1 inverted fall");
        ch1_inv = 0;

        trig_sel = 5'b00111;
        ext_pin = 1; tick(5); exp_cnt += 1;
        expect_cnt("R8 ext rise");
        ext_pin = 0; tick(5);
        expect_cnt("R8 ext fall ignored");
        ext_inv = 1;
        ext_pin = 1; tick(5);
        expect_cnt("R8 inverted rise ignored");
        ext_pin = 0; tick(5); exp_cnt += 1;
        expect_cnt("R8 inverted fall");
        ext_inv = 0;

        trig_sel = 5'b00010; tick(2);
        itr_in[2] = 1; tick(1); exp_cnt += 1;
        expect_cnt("R9 selected line");
        itr_in[1] = 1; itr_in[3] = 1; tick(3);
        expect_cnt("R9 other lines ignored");
        itr_in = '0; tick(2);

        clear_flag();
        trig_sel = 5'b01000;
        ch1_pin = 1; ch2_pin = 1; ext_pin = 1; itr_in = '1; tick(5);
        ch1_pin = 0; ch2_pin = 0; ext_pin = 0; itr_in = '0; tick(5);
        expect_both("R10 code 01000", 0);
        trig_sel = 5'b11111;
        ch1_pin = 1; ch2_pin = 1; ext_pin = 1; itr_in = '1; tick(5);
        ch1_pin = 0; ch2_pin = 0; ext_pin = 0; itr_in = '0; tick(5);
        expect_both("R10 code 11111", 0);

        trig_sel = 5'b00110; tick(2);
        ch2_pin = 1; tick(2);
        flag_clr = 1; tick(1); flag_clr = 0; exp_cnt += 1;
        expect_both("R12 set beats clear", 1);
        ch2_pin = 0; tick(5);

        slave_mode = 3'b000;
        tick(256 - (exp_cnt % 256)); exp_cnt = 0;
        expect_cnt("R2 wrap to zero");

        tick(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule